// File: doc/BRIEF.md
# Keyboard Decimal Number Entry

This block listens to a PS/2 keyboard on its clock and data lines and samples both with the system clock. It rebuilds each 11-bit frame into an 8-bit scan code. The code is shown on `scan_code` and flagged by `scan_ready` until the consumer pulses `read_ack`. For example, the key labelled A produces 8'h1C.

Alongside the raw codes, the block decodes digit keys into values 0 to 9. It folds these digits into a binary number, one decimal place at a time, so typing 2, 5, 4 gives 254 (8'b11111110). Any other key ends the entry: the number built so far is latched on `number_value` and the running value restarts from zero. Key-release prefixes are filtered, so each key press counts once.

Top module: `kbd_decimal_entry`

## Requirements
- R1: Both keyboard lines pass through a two-flop synchroniser. A bit is taken on each falling edge of the synchronised keyboard clock. A frame is a start bit of 0, then 8 data bits with the LSB first, then an odd parity bit, then a stop bit of 1. The data byte of a good frame appears on `scan_code`.
- R2: A frame with even parity over its data and parity bits, or with a stop bit of 0, is discarded. `scan_code`, `scan_ready`, `entry_value` and `number_value` keep their values.
- R3: `scan_ready` goes to 1 when a good frame completes. A completing frame wins over a `read_ack` in the same cycle.
- R4: `read_ack` with no frame completing clears `scan_ready` on the next cycle. Otherwise `scan_ready` holds.
- R5: These codes decode as the digits 0 to 9: 45, 16, 1E, 26, 25, 2E, 36, 3D, 3E, 46 (hex). With KEYPAD_EN=1 (the default), these codes also decode as 0 to 9: 70, 69, 72, 7A, 6B, 73, 74, 6C, 75, 7D (hex).
- R6: A digit d changes `entry_value` to (entry_value*10 + d) mod 2^NUM_W, so 9, 9, 9 gives 231. Without a good frame, `entry_value` does not change.
- R7: A byte of 8'hF0, and the byte that follows it, leave `entry_value` and `number_value` untouched. Both bytes are still reported on `scan_code`.
- R8: Any other byte that is not a digit (for example 8'h5A) copies `entry_value` into `number_value` and clears `entry_value`. `number_value` changes at no other time.
- R9: After reset, `scan_code`, `scan_ready`, `entry_value` and `number_value` are all 0.
- R10: All outputs change on the fourth rising edge of `clk` after the final keyboard-clock falling edge of a frame reaches the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kb_clk_i | input | 1 | Keyboard clock line |
| kb_dat_i | input | 1 | Keyboard data line |
| read_ack | input | 1 | Consumer has taken the scan code |
| scan_code | output | 8 | Last good scan code |
| scan_ready | output | 1 | Unread scan code present |
| entry_value | output | NUM_W | Number being typed |
| number_value | output | NUM_W | Last finished number |

## Verification
On every cycle, the assertions check four things:
- the ready flag rises with each good frame and then holds or clears as the read pulse dictates;
- the scan code, the running entry and the finished number move only after a completed frame;
- the finished number moves only on such a frame;
- the receiver's bit counter never leaves the frame length.

Other behaviour needs the bench's scenarios:
- the digit table, the modulo arithmetic and the release-prefix filtering;
- the rejection of frames with bad parity or a bad stop bit;
- the exact four-edge latency.

The bench checks these against its reference model on every clock.

// File: rtl/kde_pkg.sv
package kde_pkg;
   localparam int unsigned CODE_W      = 8;
   localparam int unsigned DIGIT_W     = 4;
   localparam logic [CODE_W-1:0] CODE_RELEASE = 8'hF0;

   typedef logic [CODE_W-1:0] code_t;

   typedef struct packed {
      logic               hit;
      logic [DIGIT_W-1:0] val;
   } digit_t;

   typedef enum logic {
      ACC_LIVE = 1'b0,
      ACC_SKIP = 1'b1
   } acc_mode_e;
endpackage

// File: rtl/kde_sync.sv
module kde_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   initial assert (STAGES >= 2) else $error("kde_sync: STAGES must be at least 2");

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= din;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/kde_rx.sv
module kde_rx
   import kde_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       kclk,
   input  logic       kdat,
   output logic       frame_ok,
   output code_t      frame_byte,
   output logic [3:0] bit_cnt
);
   localparam int unsigned PAR_IDX  = CODE_W + 1;
   localparam int unsigned LAST_IDX = CODE_W + 2;

   logic  kclk_prev_q;
   logic  fall;
   logic [3:0] cnt_q;
   code_t sh_q;
   logic  par_q;

   assign fall    = kclk_prev_q & ~kclk;
   assign bit_cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kclk_prev_q <= 1'b1;
         cnt_q       <= '0;
         sh_q        <= '0;
         par_q       <= 1'b0;
         frame_ok    <= 1'b0;
         frame_byte  <= '0;
      end else begin
         kclk_prev_q <= kclk;
         frame_ok    <= 1'b0;
         if (fall) begin
            if (cnt_q == 4'd0) begin
               if (!kdat) begin
                  cnt_q <= 4'd1;
                  par_q <= 1'b0;
               end
            end else if (cnt_q == 4'(LAST_IDX)) begin
               cnt_q <= '0;
               if (kdat && par_q) begin
                  frame_ok   <= 1'b1;
                  frame_byte <= sh_q;
               end
            end else if (cnt_q == 4'(PAR_IDX)) begin
               par_q <= par_q ^ kdat;
               cnt_q <= cnt_q + 4'd1;
            end else begin
               sh_q  <= {kdat, sh_q[CODE_W-1:1]};
               par_q <= par_q ^ kdat;
               cnt_q <= cnt_q + 4'd1;
            end
         end
      end
   end
endmodule

// File: rtl/kde_digit_map.sv
module kde_digit_map
   import kde_pkg::*;
#(
   parameter bit KEYPAD_EN = 1'b1
) (
   input  code_t  code,
   output digit_t digit
);
   digit_t main_d;
   digit_t pad_d;

   always_comb begin
      main_d = '{hit: 1'b1, val: '0};
      unique case (code)
         8'h45: main_d.val = 4'd0;
         8'h16: main_d.val = 4'd1;
         8'h1E: main_d.val = 4'd2;
         8'h26: main_d.val = 4'd3;
         8'h25: main_d.val = 4'd4;
         8'h2E: main_d.val = 4'd5;
         8'h36: main_d.val = 4'd6;
         8'h3D: main_d.val = 4'd7;
         8'h3E: main_d.val = 4'd8;
         8'h46: main_d.val = 4'd9;
         default: main_d.hit = 1'b0;
      endcase
   end

   generate
      if (KEYPAD_EN) begin : g_pad
         always_comb begin
            pad_d = '{hit: 1'b1, val: '0};
            unique case (code)
               8'h70: pad_d.val = 4'd0;
               8'h69: pad_d.val = 4'd1;
               8'h72: pad_d.val = 4'd2;
               8'h7A: pad_d.val = 4'd3;
               8'h6B: pad_d.val = 4'd4;
               8'h73: pad_d.val = 4'd5;
               8'h74: pad_d.val = 4'd6;
               8'h6C: pad_d.val = 4'd7;
               8'h75: pad_d.val = 4'd8;
               8'h7D: pad_d.val = 4'd9;
               default: pad_d.hit = 1'b0;
            endcase
         end
      end else begin : g_nopad
         assign pad_d = '0;
      end
   endgenerate

   assign digit = main_d.hit ? main_d : pad_d;
endmodule

// File: rtl/kde_accum.sv
module kde_accum
   import kde_pkg::*;
#(
   parameter int unsigned NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_ok,
   input  code_t            code,
   input  digit_t           digit,
   output logic [NUM_W-1:0] entry_value,
   output logic [NUM_W-1:0] number_value
);
   initial assert (NUM_W >= DIGIT_W) else $error("kde_accum: NUM_W too small");

   acc_mode_e        mode_q;
   logic [NUM_W-1:0] entry_next;

   assign entry_next = entry_value * NUM_W'(10) + NUM_W'(digit.val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= ACC_LIVE;
         entry_value  <= '0;
         number_value <= '0;
      end else if (frame_ok) begin
         if (code == CODE_RELEASE) begin
            mode_q <= ACC_SKIP;
         end else if (mode_q == ACC_SKIP) begin
            mode_q <= ACC_LIVE;
         end else if (digit.hit) begin
            entry_value <= entry_next;
         end else begin
            number_value <= entry_value;
            entry_value  <= '0;
         end
      end
   end
endmodule

// File: rtl/kbd_decimal_entry.sv
module kbd_decimal_entry
   import kde_pkg::*;
#(
   parameter int unsigned NUM_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          KEYPAD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kb_clk_i,
   input  logic             kb_dat_i,
   input  logic             read_ack,
   output logic [7:0]       scan_code,
   output logic             scan_ready,
   output logic [NUM_W-1:0] entry_value,
   output logic [NUM_W-1:0] number_value
);
   initial assert (CODE_W == 8) else $error("kbd_decimal_entry: scan code must be 8 bits");

   logic [1:0] lines_s;
   logic       frame_ok;
   code_t      frame_byte;
   logic [3:0] rx_cnt;
   digit_t     digit;

   kde_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({kb_clk_i, kb_dat_i}), .dout(lines_s)
   );

   kde_rx u_rx (
      .clk(clk), .rst_n(rst_n),
      .kclk(lines_s[1]), .kdat(lines_s[0]),
      .frame_ok(frame_ok), .frame_byte(frame_byte), .bit_cnt(rx_cnt)
   );

   kde_digit_map #(.KEYPAD_EN(KEYPAD_EN)) u_map (
      .code(frame_byte), .digit(digit)
   );

   kde_accum #(.NUM_W(NUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .frame_ok(frame_ok), .code(frame_byte), .digit(digit),
      .entry_value(entry_value), .number_value(number_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_code  <= '0;
         scan_ready <= 1'b0;
      end else if (frame_ok) begin
         scan_code  <= frame_byte;
         scan_ready <= 1'b1;
      end else if (read_ack) begin
         scan_ready <= 1'b0;
      end
   end
endmodule

// File: rtl/kde_checker.sv
module kde_checker #(
   parameter int unsigned NUM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             read_ack,
   input logic             frame_ok,
   input logic [7:0]       frame_byte,
   input logic [7:0]       scan_code,
   input logic             scan_ready,
   input logic [NUM_W-1:0] entry_value,
   input logic [NUM_W-1:0] number_value,
   input logic [3:0]       rx_cnt
);
   // R1
   bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= 4'd10);

   // R3
   ready_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> (scan_ready && scan_code == $past(frame_byte)));

   // R4
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (read_ack && !frame_ok) |=> !scan_ready);

   // R4
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_ready && !read_ack && !frame_ok) |=> scan_ready);

   // R2
   code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(scan_code));

   // R6
   entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(entry_value));

   // R8
   number_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(number_value));
endmodule

bind kbd_decimal_entry kde_checker #(.NUM_W(NUM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .read_ack(read_ack),
   .frame_ok(frame_ok), .frame_byte(frame_byte),
   .scan_code(scan_code), .scan_ready(scan_ready),
   .entry_value(entry_value), .number_value(number_value),
   .rx_cnt(rx_cnt)
);

// File: tb/tb_kbd_decimal_entry.sv
`timescale 1ns/1ps
module tb_kbd_decimal_entry;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kb_clk_i = 1'b1;
   logic kb_dat_i = 1'b1;
   logic read_ack = 1'b0;
   logic [7:0] scan_code;
   logic       scan_ready;
   logic [7:0] entry_value;
   logic [7:0] number_value;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   kbd_decimal_entry dut (
      .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
      .read_ack(read_ack), .scan_code(scan_code), .scan_ready(scan_ready),
      .entry_value(entry_value), .number_value(number_value)
   );

   // ---------------- reference model ----------------
   int pin_c[$];
   int pin_d[$];
   int m_cnt, m_sh, m_par, m_pbyte;
   bit m_pend, m_skip;
   int m_code, m_ready, m_entry, m_num;

   function automatic int digit_of(int c);
      int main_tab[10] = '{'h45, 'h16, 'h1E, 'h26, 'h25, 'h2E, 'h36, 'h3D, 'h3E, 'h46};
      int pad_tab[10]  = '{'h70, 'h69, 'h72, 'h7A, 'h6B, 'h73, 'h74, 'h6C, 'h75, 'h7D};
      for (int i = 0; i < 10; i++) begin
         if (main_tab[i] == c || pad_tab[i] == c) return i;
      end
      return -1;
   endfunction

   task automatic model_accum(int c);
      int d;
      if (c == 'hF0) m_skip = 1;
      else if (m_skip) m_skip = 0;
      else begin
         d = digit_of(c);
         if (d >= 0) m_entry = (m_entry * 10 + d) % 256;
         else begin m_num = m_entry; m_entry = 0; end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_c = '{1, 1, 1}; pin_d = '{1, 1, 1};
         m_cnt = 0; m_sh = 0; m_par = 0; m_pend = 0; m_pbyte = 0; m_skip = 0;
         m_code = 0; m_ready = 0; m_entry = 0; m_num = 0;
      end else begin
         if (m_pend) begin
            m_code = m_pbyte; m_ready = 1; model_accum(m_pbyte); m_pend = 0;
         end else if (read_ack) m_ready = 0;
         // pin_c[0] is the oldest sample (three edges back)
         if (pin_c[0] == 1 && pin_c[1] == 0) begin
            int d;
            d = pin_d[1];
            if (m_cnt == 0) begin
               if (d == 0) begin m_cnt = 1; m_par = 0; m_sh = 0; end
            end else if (m_cnt <= 8) begin
               m_sh = m_sh | (d << (m_cnt - 1)); m_par ^= d; m_cnt++;
            end else if (m_cnt == 9) begin
               m_par ^= d; m_cnt = 10;
            end else begin
               m_cnt = 0;
               if (d == 1 && m_par == 1) begin m_pend = 1; m_pbyte = m_sh; end
            end
         end
         void'(pin_c.pop_front()); void'(pin_d.pop_front());
         pin_c.push_back(int'(kb_clk_i)); pin_d.push_back(int'(kb_dat_i));
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (scan_code != m_code[7:0] || scan_ready != m_ready[0] ||
             entry_value != m_entry[7:0] || number_value != m_num[7:0]) begin
            failures++;
            $display("FAIL R10 cycle model: code=%h/%h ready=%0d/%0d entry=%0d/%0d number=%0d/%0d (actual/expected)",
                     scan_code, m_code[7:0], scan_ready, m_ready, entry_value, m_entry, number_value, m_num);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send_frame(logic [7:0] b, bit bad_par = 0, bit bad_stop = 0);
      logic [10:0] bits;
      bits = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
      for (int i = 0; i < 11; i++) begin
         @(negedge clk); kb_dat_i = bits[i];
         repeat (HALF) @(negedge clk); kb_clk_i = 1'b0;
         repeat (HALF) @(negedge clk); kb_clk_i = 1'b1;
      end
      kb_dat_i = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic pulse_read();
      @(negedge clk); read_ack = 1'b1;
      @(negedge clk); read_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic press(logic [7:0] b);
      send_frame(b); send_frame(8'hF0); send_frame(b);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 code", scan_code, 0);
      check("R9 ready", scan_ready, 0);
      check("R9 entry", entry_value, 0);
      check("R9 number", number_value, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      send_frame(8'h1C);
      check("R1 code A", scan_code, 'h1C);
      check("R3 ready set", scan_ready, 1);
      check("R8 non-digit gives zero", number_value, 0);
      pulse_read();
      check("R4 ready cleared", scan_ready, 0);

      press(8'h1E); press(8'h2E); press(8'h25);
      check("R6 entry 254", entry_value, 254);
      check("R7 release byte reported", scan_code, 'h25);
      send_frame(8'h5A);
      check("R8 number 254", number_value, 254);
      check("R8 entry cleared", entry_value, 0);

      send_frame(8'h7A); send_frame(8'h73);
      check("R5 keypad entry 35", entry_value, 35);
      send_frame(8'h5A);
      check("R5 keypad number 35", number_value, 35);

      press(8'h46); press(8'h46); press(8'h46);
      check("R6 wrap 999", entry_value, 231);
      send_frame(8'h5A);
      check("R8 number 231", number_value, 231);
      pulse_read();

      send_frame(8'h16, 1'b1, 1'b0);
      check("R2 bad parity code", scan_code, 'h5A);
      check("R2 bad parity ready", scan_ready, 0);
      check("R2 bad parity entry", entry_value, 0);
      send_frame(8'h16, 1'b0, 1'b1);
      check("R2 bad stop code", scan_code, 'h5A);
      check("R2 bad stop entry", entry_value, 0);

      send_frame(8'h3D);
      check("R5 digit 7", entry_value, 7);
      @(negedge clk); read_ack = 1'b1;
      send_frame(8'h45);
      check("R3 code during read", scan_code, 'h45);
      check("R3 ready after held read", scan_ready, 0);
      check("R6 entry 70", entry_value, 70);
      read_ack = 1'b0;
      send_frame(8'h66);
      check("R8 number 70", number_value, 70);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule